// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block is the interrupt unit of a small microcontroller. It accepts three request sources: an external interrupt pin that requests on a falling edge, and overflow pulses from two timers. It keeps one control byte. That byte holds a global enable, one enable bit per source and one pending flag per source. Software reads the byte at any time and overwrites it through a simple write port.

When the global enable is on and the return-address stack has room, the unit picks the pending, enabled source with the highest rank. It then raises a one-cycle call request that carries the fixed entry address for that source. It waits for the CPU to acknowledge the call. On that acknowledge it clears the served flag and the global enable, so the handler runs without being nested. The CPU core, the stack and the timers sit outside the block.

Top module: `prio_irq_unit`

## Requirements
- R1: After synchronous reset every bit of the control byte reads 0 and no call request is raised.
- R2: The control byte reads as follows: bit 0 is the global enable. Bits 1, 2 and 3 enable the external, timer 0 and timer 1 sources. Bits 4, 5 and 6 are their pending flags. Bit 7 always reads 0.
- R3: A write replaces bits 0 to 6 with the written data, so software may set or clear any enable or flag; the written bit 7 is discarded.
- R4: The external pin passes through a two-flop synchroniser. A high-to-low transition sets bit 4 on the third clock edge after the pin falls. A rising edge or a steady level sets nothing.
- R5: A timer overflow pulse sampled high at a clock edge sets that timer's flag (bit 5 or bit 6) at the same edge.
- R6: When a hardware set event and a write hit the same flag in the same cycle, the flag ends up set.
- R7: A call request is raised only if, in the previous cycle, the global enable, the source's enable and the source's flag were all set and stack_full_i was low. The request lasts exactly one cycle.
- R8: The entry address is 8'h04 for the external source, 8'h08 for timer 0 and 8'h0C for timer 1.
- R9: When several sources qualify, the external source wins, then timer 0, then timer 1.
- R10: A call acknowledge that arrives while a request is outstanding clears the served source's flag and the global enable, and leaves the other bits as they were. An acknowledge with nothing outstanding changes nothing.
- R11: From the request until its acknowledge, no further request is raised, even if software sets the global enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin, falling-edge active |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| stack_full_i | input | 1 | High while the call stack cannot take another entry |
| bus_we_i | input | 1 | Write strobe for the control byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Current control byte |
| call_req_o | output | 1 | One-cycle subroutine call request |
| call_vec_o | output | 8 | Entry address, valid with call_req_o |
| call_ack_i | input | 1 | CPU acknowledge of the outstanding call |

## Verification
The bench covers several corner cases, each tied to a specific fault:
- A write that clears a flag in the same cycle as an overflow pulse. A design that let the write win would lose the event.
- An acknowledge with no request outstanding. A design that ignored the busy state would wipe the global enable and a flag.
- Software re-enabling the global enable before the acknowledge. A design that did not track the outstanding call would fire a second, nested request.
- All three flags pending while the stack is full, then the stack freeing up. This catches a wrong rank order or a missing stack qualifier.
- The exact edge on which a falling pin shows up in bit 4, and a rising pin that must set nothing. This exposes a synchroniser of the wrong depth or the wrong edge polarity.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int unsigned NSRC = 3;

    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] en;
        logic            master;
    } ctl_reg_t;

    localparam int unsigned REG_W = $bits(ctl_reg_t);

    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_WAIT = 1'b1
    } svc_state_t;

    function automatic logic [7:0] vec_of(input int unsigned base,
                                          input int unsigned step,
                                          input int unsigned idx);
        return 8'(base + idx * step);
    endfunction

endpackage

// File: rtl/prio_irq_fall.sv
module prio_irq_fall #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[DEPTH-2:0], pin_i};
    end

    // older sample high, newer synchronised sample low
    assign fall_o = shreg[DEPTH-1] & ~shreg[DEPTH-2];
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [NSRC-1:0]  hw_set_i,
    input  logic             ack_clr_i,
    input  logic [NSRC-1:0]  ack_src_i,
    output ctl_reg_t         q_o
);
    ctl_reg_t q, nxt;

    always_comb begin
        nxt = q;
        if (we_i) nxt = ctl_reg_t'(wdata_i);
        if (ack_clr_i) begin
            nxt.master = 1'b0;
            nxt.flag   = nxt.flag & ~ack_src_i;
        end
        nxt.flag = nxt.flag | hw_set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign q_o = q;
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int unsigned VEC_BASE = 4,
    parameter int unsigned VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  ctl_reg_t        ctl_i,
    input  logic            stack_full_i,
    input  logic            ack_i,
    output logic            req_o,
    output logic [7:0]      vec_o,
    output logic            ack_clr_o,
    output logic [NSRC-1:0] ack_src_o,
    output logic            busy_o
);
    logic [NSRC-1:0] pend, win;
    logic [NSRC:0]   blocked;
    logic [7:0]      vec_n;
    logic            take;
    svc_state_t      state;
    logic [NSRC-1:0] src_q;

    assign pend       = ctl_i.flag & ctl_i.en;
    assign blocked[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_rank
            assign win[gi]       = pend[gi] & ~blocked[gi];
            assign blocked[gi+1] = blocked[gi] | pend[gi];
        end
    endgenerate

    always_comb begin
        vec_n = '0;
        for (int i = 0; i < NSRC; i++)
            if (win[i]) vec_n = vec_of(VEC_BASE, VEC_STEP, i);
    end

    assign take = (state == SVC_IDLE) & ctl_i.master & ~stack_full_i & (|pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SVC_IDLE;
            req_o <= 1'b0;
            vec_o <= '0;
            src_q <= '0;
        end else begin
            req_o <= take;
            if (take) begin
                state <= SVC_WAIT;
                vec_o <= vec_n;
                src_q <= win;
            end else if (state == SVC_WAIT && ack_i) begin
                state <= SVC_IDLE;
            end
        end
    end

    assign ack_clr_o = (state == SVC_WAIT) & ack_i;
    assign ack_src_o = src_q;
    assign busy_o    = (state == SVC_WAIT);
endmodule

// File: rtl/prio_irq_unit.sv
module prio_irq_unit
    import prio_irq_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VEC_BASE    = 4,
    parameter int unsigned VEC_STEP    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin_i,
    input  logic              tmr0_ovf_i,
    input  logic              tmr1_ovf_i,
    input  logic              stack_full_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              call_req_o,
    output logic [7:0]        call_vec_o,
    input  logic              call_ack_i
);
    ctl_reg_t        ctl;
    logic            ext_fall;
    logic [NSRC-1:0] hw_set;
    logic            ack_clr;
    logic [NSRC-1:0] ack_src;
    logic            svc_busy;
    logic            unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:REG_W];

    prio_irq_fall #(.STAGES(SYNC_STAGES)) u_fall (
        .clk   (clk),
        .rst   (rst),
        .pin_i (ext_pin_i),
        .fall_o(ext_fall)
    );

    assign hw_set = {tmr1_ovf_i, tmr0_ovf_i, ext_fall};

    prio_irq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we_i     (bus_we_i),
        .wdata_i  (bus_wdata_i[REG_W-1:0]),
        .hw_set_i (hw_set),
        .ack_clr_i(ack_clr),
        .ack_src_i(ack_src),
        .q_o      (ctl)
    );

    prio_irq_arb #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (ctl),
        .stack_full_i(stack_full_i),
        .ack_i       (call_ack_i),
        .req_o       (call_req_o),
        .vec_o       (call_vec_o),
        .ack_clr_o   (ack_clr),
        .ack_src_o   (ack_src),
        .busy_o      (svc_busy)
    );

    assign bus_rdata_o = {{(DATA_W-REG_W){1'b0}}, ctl};
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       stack_full_i,
    input logic [7:0] bus_rdata_o,
    input logic       call_req_o,
    input logic [7:0] call_vec_o,
    input logic       call_ack_i,
    input logic       svc_busy
);
    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        call_req_o |=> !call_req_o);

    // R7
    req_stack_chk: assert property (@(posedge clk) disable iff (rst)
        call_req_o |-> $past(!stack_full_i && bus_rdata_o[0]));

    // R8
    vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
        call_req_o |-> (call_vec_o == 8'h04 || call_vec_o == 8'h08 || call_vec_o == 8'h0C));

    // R2
    top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_o[7] == 1'b0);

    // R9
    rank_chk: assert property (@(posedge clk) disable iff (rst)
        (call_req_o && call_vec_o != 8'h04) |-> $past(!(bus_rdata_o[1] && bus_rdata_o[4])));

    // R10
    ack_master_chk: assert property (@(posedge clk) disable iff (rst)
        (call_ack_i && svc_busy) |=> !bus_rdata_o[0]);

    // R11
    no_nest_chk: assert property (@(posedge clk) disable iff (rst)
        call_req_o |-> $past(!svc_busy));
endmodule

bind prio_irq_unit prio_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .stack_full_i(stack_full_i),
    .bus_rdata_o (bus_rdata_o),
    .call_req_o  (call_req_o),
    .call_vec_o  (call_vec_o),
    .call_ack_i  (call_ack_i),
    .svc_busy    (svc_busy)
);

// File: tb/prio_irq_unit_tb.sv
module prio_irq_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin_i = 1'b1;
    logic       tmr0_ovf_i = 1'b0;
    logic       tmr1_ovf_i = 1'b0;
    logic       stack_full_i = 1'b0;
    logic       bus_we_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       call_req_o;
    logic [7:0] call_vec_o;
    logic       call_ack_i = 1'b0;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic [6:0] m_reg;
    logic       m_s1, m_s2, m_s3;
    logic       m_busy, m_req;
    logic [1:0] m_src;
    logic [7:0] m_vec;

    always #2 clk = ~clk;

    prio_irq_unit u_dut (
        .clk(clk), .rst(rst), .ext_pin_i(ext_pin_i), .tmr0_ovf_i(tmr0_ovf_i),
        .tmr1_ovf_i(tmr1_ovf_i), .stack_full_i(stack_full_i), .bus_we_i(bus_we_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .call_req_o(call_req_o),
        .call_vec_o(call_vec_o), .call_ack_i(call_ack_i)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_vec(input int idx);
        return 8'(4 + 4 * idx);
    endfunction

    task automatic model_step();
        logic [2:0] set, pend;
        logic [6:0] nreg;
        logic       ackv, fall;
        fall = m_s3 & ~m_s2;
        set  = {tmr1_ovf_i, tmr0_ovf_i, fall};
        ackv = call_ack_i & m_busy;
        nreg = m_reg;
        if (bus_we_i) nreg = bus_wdata_i[6:0];
        if (ackv) begin
            nreg[0] = 1'b0;
            nreg[4 + m_src] = 1'b0;
        end
        nreg[6:4] = nreg[6:4] | set;
        pend = m_reg[6:4] & m_reg[3:1];
        m_req = 1'b0;
        if (!m_busy && m_reg[0] && !stack_full_i && pend != 3'b000) begin
            m_req  = 1'b1;
            m_busy = 1'b1;
            m_src  = pend[0] ? 2'd0 : (pend[1] ? 2'd1 : 2'd2);
            m_vec  = exp_vec(int'(m_src));
        end else if (ackv) begin
            m_busy = 1'b0;
        end
        m_reg = nreg;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin_i;
    endtask

    // apply one cycle of inputs, then compare all outputs against the model
    task automatic cyc(input logic pin, input logic t0, input logic t1, input logic sf,
                       input logic we, input logic [7:0] wd, input logic ack);
        ext_pin_i = pin; tmr0_ovf_i = t0; tmr1_ovf_i = t1; stack_full_i = sf;
        bus_we_i = we; bus_wdata_i = wd; call_ack_i = ack;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R2 read", bus_rdata_o, {1'b0, m_reg});
        check("R7 req", {7'b0, call_req_o}, {7'b0, m_req});
        if (m_req) check("R8 vec", call_vec_o, m_vec);
    endtask

    task automatic idle(input logic pin);
        cyc(pin, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic wr(input logic [7:0] d);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, d, 1'b0);
    endtask

    task automatic ack1();
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        m_reg = '0; m_s1 = 1; m_s2 = 1; m_s3 = 1;
        m_busy = 0; m_req = 0; m_src = '0; m_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        check("R1 reset reg", bus_rdata_o, 8'h00);
        check("R1 reset req", {7'b0, call_req_o}, 8'h00);

        // R3 bit 7 discarded
        wr(8'h8F);
        check("R3 write", bus_rdata_o, 8'h0F);

        // R7 master off blocks
        wr(8'h7E);
        idle(1'b1);
        check("R7 no master", {7'b0, call_req_o}, 8'h00);

        // R7 stack full blocks, R9 external first
        cyc(1'b1, 0, 0, 1'b1, 1'b1, 8'h7F, 0);
        cyc(1'b1, 0, 0, 1'b1, 1'b0, 8'h00, 0);
        check("R7 stack full", {7'b0, call_req_o}, 8'h00);
        idle(1'b1);
        check("R9 ext wins", call_vec_o, 8'h04);
        check("R7 req high", {7'b0, call_req_o}, 8'h01);
        wr(8'h7F);
        check("R7 pulse", {7'b0, call_req_o}, 8'h00);
        idle(1'b1);
        check("R11 no nest", {7'b0, call_req_o}, 8'h00);
        ack1();
        check("R10 ack clear", bus_rdata_o, 8'h6E);
        ack1();
        check("R10 idle ack", bus_rdata_o, 8'h6E);

        // R9 timer 0 then timer 1
        wr(8'h6F);
        idle(1'b1);
        check("R9 t0 next", call_vec_o, 8'h08);
        ack1();
        check("R10 t0 clear", bus_rdata_o, 8'h4E);
        wr(8'h4F);
        idle(1'b1);
        check("R8 t1 vec", call_vec_o, 8'h0C);
        ack1();
        check("R10 t1 clear", bus_rdata_o, 8'h0E);

        // R6 set beats write, R5 timer 1 set
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        check("R6 set wins", bus_rdata_o, 8'h20);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R5 t1 set", bus_rdata_o, 8'h60);

        // R4 falling edge timing
        wr(8'h00);
        idle(1'b0);
        idle(1'b0);
        check("R4 not yet", bus_rdata_o, 8'h00);
        idle(1'b0);
        check("R4 fall", bus_rdata_o, 8'h10);
        idle(1'b0);
        idle(1'b0);
        cyc(1'b0, 0, 0, 0, 1'b1, 8'h00, 0);
        idle(1'b1);
        idle(1'b1);
        idle(1'b1);
        idle(1'b1);
        check("R4 rise ignored", bus_rdata_o, 8'h00);

        // constrained random against the model
        void'($urandom(32'd20240611));
        begin
            logic pin;
            pin = 1'b1;
            for (int n = 0; n < 4000; n++) begin
                logic [7:0] wd;
                if ($urandom_range(0, 7) == 0) pin = ~pin;
                wd = 8'($urandom());
                if ($urandom_range(0, 3) != 0) wd[0] = 1'b1;
                cyc(pin,
                    $urandom_range(0, 7) == 0,
                    $urandom_range(0, 7) == 0,
                    $urandom_range(0, 3) == 0,
                    $urandom_range(0, 5) == 0,
                    wd,
                    $urandom_range(0, 2) == 0);
            end
        end

        summary();
        $finish;
    end
endmodule